// File: doc/BRIEF.md
# Flash Code Read Protection Controller

This block decides which debug and programming paths may reach the on-chip flash. After reset it takes one 32-bit protection word, read from a fixed flash location, and decodes it into one of four security levels: open, or protected at grade one, two or three. The chosen level then drives three things. It gates the JTAG debug enable. It decides whether the serial boot programming mode may be entered. It judges every programming command that the boot loader forwards, and each command receives an accept or reject answer one cycle later.

Commands issued by running firmware through in-application programming are marked as such. They pass through the same format checks but are never refused on protection grounds. A full-chip erase that completes while the level is one or two clears the protection for the rest of the session, because the erase also wipes the protection word. The flash array, the boot loader, the JTAG TAP and the serial port sit outside the block and appear only as request and grant signals.

Top module: `flash_guard`

## Requirements
- R1: The protection word decodes as 0x12345678 to level 1, 0x87654321 to level 2 and 0x43218765 to level 3. Every other value decodes to level 0 (open). `prot_level` reports the level with the same numbers 0 to 3.
- R2: The level is taken from the first cycle after reset release in which `prot_word_valid` is high. It then stays fixed until the next reset, whatever later values appear on `prot_word`. The only exception is the clearing described in R10.
- R3: `dbg_en` is low from reset until the level has been taken. After that it is high only while the level is 0.
- R4: At level 1, a boot-path command is accepted only if it is a sector write or a sector erase whose first sector is not 0, a blank check, or a full-chip erase. Reads and go commands are rejected, and so is any write or sector erase whose range begins at sector 0.
- R5: At level 2, the only boot-path command accepted is a full-chip erase.
- R6: At level 3, every boot-path command is rejected. At level 0, every well-formed boot-path command is accepted.
- R7: `boot_grant` is high when the level has been taken and either `fw_boot_req` is high, or `boot_pin` is high and the level is not 3. At level 3 the pin alone never grants entry.
- R8: A command with `cmd_iap` high is never rejected with the access-denied code, whatever the level and whether or not the level has been taken.
- R9: Each cycle with `cmd_valid` high produces exactly one `rsp_valid` pulse in the next cycle. The opcodes are 0 read, 1 sector write, 2 sector erase, 3 full-chip erase, 4 blank check and 5 go. The `rsp_err` codes are 0 OK, 1 access denied, 2 unknown opcode (6 or 7) and 3 bad range. A bad range means a ranged opcode (0, 1, 2, 4) with `cmd_first` > `cmd_last` or `cmd_last` ≥ NSECT (NSECT is 12 by default). An unknown opcode takes priority over a bad range, and a bad range takes priority over access denied. `rsp_ok` is high exactly when the code is 0.
- R10: A `chip_erase_done` pulse while the level is 1 or 2 sets the level to 0 from the next cycle on. At level 3 or level 0 it has no effect.
- R11: Until the level has been taken, every boot-path command is rejected with access denied and `boot_grant` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_word_valid | input | 1 | Protection word on `prot_word` is valid this cycle |
| prot_word | input | 32 | Protection word read from the flash |
| chip_erase_done | input | 1 | Pulse when a full-chip erase completes |
| boot_pin | input | 1 | External pin that requests boot programming mode |
| fw_boot_req | input | 1 | Firmware request to re-enter boot programming mode |
| cmd_valid | input | 1 | Programming command present |
| cmd_iap | input | 1 | 1 = in-application command, 0 = boot-path command |
| cmd_op | input | 3 | Command opcode |
| cmd_first | input | SW | First sector of the range |
| cmd_last | input | SW | Last sector of the range |
| dbg_en | output | 1 | JTAG debug access enable |
| boot_grant | output | 1 | Entry into boot programming mode permitted |
| prot_level | output | 2 | Active protection level |
| rsp_valid | output | 1 | Response to the previous cycle's command |
| rsp_ok | output | 1 | Command accepted |
| rsp_err | output | 2 | Result code |

## Verification
The hardest situation to reach from the ports is the boundary between level capture and the first command. The reference model expects the old rules in the capture cycle and the new level's rules one cycle later. To reach it, the bench issues boot-path commands and holds `boot_pin` high before, during and after the single valid cycle. It then presents a second, different protection word to show that the level is not taken again. The clearing by full-chip erase is reached only after a level-1 or level-2 session has been built. The bench therefore drives the erase pulse in each protected session, including level 3 where the pulse must do nothing, and follows it with sector-0 writes whose answer shows which level is in force.

// File: rtl/fg_pkg.sv
package fg_pkg;

    typedef enum logic [1:0] {
        LV_OPEN  = 2'd0,
        LV_ONE   = 2'd1,
        LV_TWO   = 2'd2,
        LV_THREE = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        ER_OK     = 2'd0,
        ER_DENIED = 2'd1,
        ER_BADOP  = 2'd2,
        ER_RANGE  = 2'd3
    } err_e;

    localparam logic [2:0] OP_READ       = 3'd0;
    localparam logic [2:0] OP_WRITE      = 3'd1;
    localparam logic [2:0] OP_ERASE_SECT = 3'd2;
    localparam logic [2:0] OP_ERASE_ALL  = 3'd3;
    localparam logic [2:0] OP_BLANK      = 3'd4;
    localparam logic [2:0] OP_GO         = 3'd5;

    localparam logic [31:0] KEY_ONE   = 32'h1234_5678;
    localparam logic [31:0] KEY_TWO   = 32'h8765_4321;
    localparam logic [31:0] KEY_THREE = 32'h4321_8765;

    typedef struct packed {
        logic       iap;
        logic [2:0] op;
    } cmd_hdr_t;

    function automatic lvl_e decode_key(input logic [31:0] w);
        case (w)
            KEY_ONE:   return LV_ONE;
            KEY_TWO:   return LV_TWO;
            KEY_THREE: return LV_THREE;
            default:   return LV_OPEN;
        endcase
    endfunction

    function automatic logic op_known(input logic [2:0] op);
        return op <= OP_GO;
    endfunction

    function automatic logic op_ranged(input logic [2:0] op);
        return (op == OP_READ) || (op == OP_WRITE) ||
               (op == OP_ERASE_SECT) || (op == OP_BLANK);
    endfunction

    // Whitelist for commands from the boot loader, per level.
    function automatic logic boot_permit(input lvl_e lv, input logic [2:0] op,
                                         input logic hits_zero);
        case (lv)
            LV_OPEN: return 1'b1;
            LV_ONE: begin
                case (op)
                    OP_WRITE, OP_ERASE_SECT: return !hits_zero;
                    OP_BLANK, OP_ERASE_ALL:  return 1'b1;
                    default:                 return 1'b0;
                endcase
            end
            LV_TWO:  return op == OP_ERASE_ALL;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fg_level_latch.sv
module fg_level_latch
    import fg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        word_valid,
    input  logic [31:0] word,
    input  logic        erase_done,
    output lvl_e        level,
    output logic        ready
);

    logic unlockable;
    assign unlockable = (level == LV_ONE) || (level == LV_TWO);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= LV_OPEN;
            ready <= 1'b0;
        end else if (!ready) begin
            if (word_valid) begin
                level <= decode_key(word);
                ready <= 1'b1;
            end
        end else if (erase_done && unlockable) begin
            // Erased array also erased the key: session is open from now on.
            level <= LV_OPEN;
        end
    end

endmodule

// File: rtl/fg_cmd_filter.sv
module fg_cmd_filter
    import fg_pkg::*;
#(
    parameter int NSECT = 12,
    parameter int SW    = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ready,
    input  lvl_e          level,
    input  logic          cmd_valid,
    input  cmd_hdr_t      hdr,
    input  logic [SW-1:0] first,
    input  logic [SW-1:0] last,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output err_e          rsp_err
);

    localparam bit FULL_SPAN = (NSECT == (1 << SW));

    logic last_in;
    generate
        if (FULL_SPAN) begin : g_full
            assign last_in = 1'b1;
        end else begin : g_part
            localparam logic [SW-1:0] LAST_IDX = SW'(NSECT - 1);
            assign last_in = (last <= LAST_IDX);
        end
    endgenerate

    logic known, range_bad, permit;
    err_e verdict;

    always_comb begin
        known     = op_known(hdr.op);
        range_bad = op_ranged(hdr.op) && ((first > last) || !last_in);
        permit    = hdr.iap ||
                    (ready && boot_permit(level, hdr.op, first == '0));
        if (!known)         verdict = ER_BADOP;
        else if (range_bad) verdict = ER_RANGE;
        else if (!permit)   verdict = ER_DENIED;
        else                verdict = ER_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= ER_OK;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_ok    <= cmd_valid && (verdict == ER_OK);
            rsp_err   <= cmd_valid ? verdict : ER_OK;
        end
    end

endmodule

// File: rtl/fg_access_gate.sv
module fg_access_gate
    import fg_pkg::*;
(
    input  logic ready,
    input  lvl_e level,
    input  logic boot_pin,
    input  logic fw_boot_req,
    output logic dbg_en,
    output logic boot_grant
);

    logic pin_honoured;

    always_comb begin
        pin_honoured = boot_pin && (level != LV_THREE);
        dbg_en       = ready && (level == LV_OPEN);
        boot_grant   = ready && (pin_honoured || fw_boot_req);
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import fg_pkg::*;
#(
    parameter int NSECT = 12,
    parameter int SW    = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prot_word_valid,
    input  logic [31:0]   prot_word,
    input  logic          chip_erase_done,
    input  logic          boot_pin,
    input  logic          fw_boot_req,
    input  logic          cmd_valid,
    input  logic          cmd_iap,
    input  logic [2:0]    cmd_op,
    input  logic [SW-1:0] cmd_first,
    input  logic [SW-1:0] cmd_last,
    output logic          dbg_en,
    output logic          boot_grant,
    output logic [1:0]    prot_level,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic [1:0]    rsp_err
);

    lvl_e     level;
    logic     lvl_ready;
    cmd_hdr_t hdr;
    err_e     err_q;

    assign hdr.iap = cmd_iap;
    assign hdr.op  = cmd_op;

    fg_level_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .word_valid (prot_word_valid),
        .word       (prot_word),
        .erase_done (chip_erase_done),
        .level      (level),
        .ready      (lvl_ready)
    );

    fg_cmd_filter #(.NSECT(NSECT), .SW(SW)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .ready     (lvl_ready),
        .level     (level),
        .cmd_valid (cmd_valid),
        .hdr       (hdr),
        .first     (cmd_first),
        .last      (cmd_last),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .rsp_err   (err_q)
    );

    fg_access_gate u_gate (
        .ready       (lvl_ready),
        .level       (level),
        .boot_pin    (boot_pin),
        .fw_boot_req (fw_boot_req),
        .dbg_en      (dbg_en),
        .boot_grant  (boot_grant)
    );

    assign prot_level = level;
    assign rsp_err    = err_q;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       lvl_ready,
    input logic       chip_erase_done,
    input logic       boot_pin,
    input logic       fw_boot_req,
    input logic       cmd_valid,
    input logic       cmd_iap,
    input logic       dbg_en,
    input logic       boot_grant,
    input logic [1:0] prot_level,
    input logic       rsp_valid,
    input logic       rsp_ok,
    input logic [1:0] rsp_err
);

    // R3: no debug access before the level is known
    assert_dbg_locked_R3: assert property (@(posedge clk) disable iff (rst)
        !lvl_ready |-> !dbg_en);

    // R3: debug only when open
    assert_dbg_open_only_R3: assert property (@(posedge clk) disable iff (rst)
        dbg_en |-> (prot_level == 2'd0));

    // R2: level holds once taken unless an erase clears it
    assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (lvl_ready && !chip_erase_done) |=> $stable(prot_level));

    // R7: pin alone never grants at level 3
    assert_pin_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (prot_level == 2'd3 && !fw_boot_req) |-> !boot_grant);

    // R11: no boot entry before the level is known
    assert_boot_wait_R11: assert property (@(posedge clk) disable iff (rst)
        !lvl_ready |-> !boot_grant);

    // R8: in-application commands never denied
    assert_iap_exempt_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_iap) |=> (rsp_err != 2'd1));

    // R9: one response per command, one cycle later
    assert_rsp_follow_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);
    assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);
    assert_rsp_ok_code_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_ok == (rsp_err == 2'd0)));

    // R6: level 3 rejects every boot-path command
    assert_l3_boot_denied_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_iap && prot_level == 2'd3) |=> !rsp_ok);

    // R10: erase clears levels 1 and 2
    assert_erase_unlock_R10: assert property (@(posedge clk) disable iff (rst)
        (lvl_ready && chip_erase_done && (prot_level == 2'd1 || prot_level == 2'd2))
        |=> (prot_level == 2'd0));

endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .lvl_ready       (lvl_ready),
    .chip_erase_done (chip_erase_done),
    .boot_pin        (boot_pin),
    .fw_boot_req     (fw_boot_req),
    .cmd_valid       (cmd_valid),
    .cmd_iap         (cmd_iap),
    .dbg_en          (dbg_en),
    .boot_grant      (boot_grant),
    .prot_level      (prot_level),
    .rsp_valid       (rsp_valid),
    .rsp_ok          (rsp_ok),
    .rsp_err         (rsp_err)
);

// File: tb/flash_guard_test.sv
`timescale 1ns/1ps
module flash_guard_test;

    localparam int NSECT = 12;
    localparam int SW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prot_word_valid = 1'b0;
    logic [31:0]   prot_word = 32'h0;
    logic          chip_erase_done = 1'b0;
    logic          boot_pin = 1'b0;
    logic          fw_boot_req = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_iap = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [SW-1:0] cmd_first = '0;
    logic [SW-1:0] cmd_last = '0;
    logic          dbg_en, boot_grant, rsp_valid, rsp_ok;
    logic [1:0]    prot_level, rsp_err;

    always #2.5 clk = ~clk;

    flash_guard #(.NSECT(NSECT), .SW(SW)) uut (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int    m_ready = 0;
    int    m_lvl = 0;
    bit    e_rv = 0;
    int    e_err = 0;
    string e_tag = "R9";
    string lvl_tag = "R1";
    bit    started = 0;

    function automatic void expect_cmd(output int err, output string tag);
        bit known  = (cmd_op <= 3'd5);
        bit ranged = (cmd_op == 3'd0 || cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd4);
        bit badr   = ranged && ((cmd_first > cmd_last) || (cmd_last >= NSECT));
        bit allow;
        if (cmd_iap)            begin allow = 1; tag = "R8"; end
        else if (m_ready == 0)  begin allow = 0; tag = "R11"; end
        else if (m_lvl == 0)    begin allow = 1; tag = "R6"; end
        else if (m_lvl == 1) begin
            tag = "R4";
            if (cmd_op == 3'd1 || cmd_op == 3'd2) allow = (cmd_first != 0);
            else allow = (cmd_op == 3'd3 || cmd_op == 3'd4);
        end
        else if (m_lvl == 2)    begin allow = (cmd_op == 3'd3); tag = "R5"; end
        else                    begin allow = 0; tag = "R6"; end
        if (!known)      begin err = 2; tag = "R9"; end
        else if (badr)   begin err = 3; tag = "R9"; end
        else if (!allow) err = 1;
        else             err = 0;
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_ready = 0; m_lvl = 0; e_rv = 0; lvl_tag = "R1";
        end else begin
            e_rv = cmd_valid;
            if (cmd_valid) expect_cmd(e_err, e_tag);
            if (m_ready == 0 && prot_word_valid) begin
                m_ready = 1;
                case (prot_word)
                    32'h12345678: m_lvl = 1;
                    32'h87654321: m_lvl = 2;
                    32'h43218765: m_lvl = 3;
                    default:      m_lvl = 0;
                endcase
                lvl_tag = "R1";
            end else if (m_ready == 1 && chip_erase_done) begin
                if (m_lvl == 1 || m_lvl == 2) m_lvl = 0;
                lvl_tag = "R10";
            end else if (m_ready == 1 && prot_word_valid) begin
                lvl_tag = "R2";
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            check(lvl_tag, prot_level, m_lvl);
            check("R3", dbg_en, (m_ready == 1 && m_lvl == 0));
            check((m_ready == 0) ? "R11" : "R7", boot_grant,
                  (m_ready == 1) && ((boot_pin && m_lvl != 3) || fw_boot_req));
            check("R9", rsp_valid, e_rv);
            if (e_rv) begin
                check(e_tag, rsp_err, e_err);
                check(e_tag, rsp_ok, (e_err == 0));
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        cmd_valid = 0; prot_word_valid = 0; chip_erase_done = 0;
        boot_pin = 0; fw_boot_req = 0; cmd_iap = 0;
    endtask

    task automatic cmd(bit iap, int op, int f, int l);
        cmd_valid = 1; cmd_iap = iap; cmd_op = 3'(op);
        cmd_first = SW'(f); cmd_last = SW'(l);
        tick(); idle();
    endtask

    task automatic do_reset();
        rst = 1; idle(); tick(); tick(); rst = 0; tick();
    endtask

    task automatic load(logic [31:0] w);
        prot_word = w; prot_word_valid = 1; tick(); idle();
    endtask

    task automatic sweep();
        for (int op = 0; op < 8; op++) begin
            cmd(0, op, 0, 2);
            cmd(0, op, 1, 3);
            cmd(1, op, 0, 1);
        end
        cmd(0, 1, 3, 1);       // R9 reversed range
        cmd(0, 2, 2, 13);      // R9 past last sector
        cmd(0, 7, 5, 1);       // R9 bad opcode beats bad range
        boot_pin = 1; tick(); idle();     // R7 pin
        fw_boot_req = 1; tick(); idle();  // R7 firmware request
        for (int i = 0; i < 60; i++) begin
            cmd_valid = 1; cmd_iap = 1'($urandom_range(0, 1));
            cmd_op = 3'($urandom_range(0, 7));
            cmd_first = SW'($urandom_range(0, 15));
            cmd_last = SW'($urandom_range(0, 15));
            boot_pin = 1'($urandom_range(0, 1));
            tick(); idle();
        end
    endtask

    task automatic session(logic [31:0] key);
        do_reset();
        // R11: before capture
        cmd(0, 3, 0, 0); cmd(1, 1, 0, 0);
        boot_pin = 1; fw_boot_req = 1; tick(); idle();
        // capture with a command in the same cycle
        prot_word = key; prot_word_valid = 1; boot_pin = 1;
        cmd_valid = 1; cmd_op = 3'd1; cmd_first = '0; cmd_last = '0;
        tick(); idle();
        cmd(0, 1, 0, 0);
        load(32'h12345678 ^ key ^ 32'h43218765); // R2: ignored
        sweep();
        chip_erase_done = 1; tick(); idle();     // R10
        cmd(0, 1, 0, 0); cmd(0, 0, 0, 1);
        sweep();
    endtask

    initial begin
        session(32'h12345678);
        session(32'h87654321);
        session(32'h43218765);
        session(32'hDEADBEEF);
        session(32'h12345679);
        tick(); tick();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule